// File: doc/BRIEF.md
# Delayed Branch and Control Unit

This unit chooses the next program counter for an in-order core whose control transfers take effect one instruction late. The instruction fetched directly after any redirecting instruction is always executed (the delay slot). Only then does control move to the new target. The unit evaluates four compare-and-branch conditions on two register operands: less-than, less-or-equal, equal and not-equal. It also handles an unconditional relative jump, jump-and-link through a register, and return-from-interrupt through a register.

The unit also holds the interrupt-enable flag. Enable and disable instructions set and clear this flag. A software interrupt is accepted only while the flag is set; otherwise the unit reports it as illegal.

The core presents one decoded instruction per cycle on the issue inputs, together with its PC and operands, and qualifies it with a valid bit. The unit answers in the same cycle with the PC of the following instruction and with a link value and its write enable. Internal state advances at the clock edge only for valid instructions. That state is the pending delay-slot redirect and the interrupt-enable flag.

Top module: `branch_ctrl_unit`

## Requirements
- R1: After reset, the interrupt-enable output `irq_en_o` is low and no redirect is pending, so the first instruction gets `next_pc_o = pc_i + 4`.
- R2: Operation codes on `op_i` are: 0 plain, 1 branch-if-less, 2 branch-if-less-or-equal, 3 branch-if-equal, 4 branch-if-not-equal, 5 jump, 6 jump-and-link, 7 return-from-interrupt, 8 enable, 9 disable, 10 software interrupt. Codes 11 to 15 act as plain. A plain instruction with no pending redirect gives `next_pc_o = pc_i + 4` and `link_we_o = 0`.
- R3: A redirecting instruction gives `next_pc_o = pc_i + 4`, which is its delay slot. The slot instruction, issued next, gets the target as its `next_pc_o`. For codes 1 to 5, the target is the redirecting instruction's PC + 4 + (sign-extended `offset_i` shifted left by 2).
- R4: Branch-if-less is taken when `rs_a_i < rs_b_i` under signed two's-complement order. Branch-if-less-or-equal is taken when `rs_a_i <= rs_b_i` under the same order. When not taken, no redirect follows.
- R5: Branch-if-equal is taken only when the operands are equal. Branch-if-not-equal is taken only when they differ.
- R6: Jump (code 5) always redirects to its relative target.
- R7: Jump-and-link drives `link_we_o = 1` and `link_o = pc_i + 8`, and redirects after the slot to the value of `rs_b_i`.
- R8: Return-from-interrupt redirects after the slot to the value of `rs_a_i` and writes no link.
- R9: A software interrupt issued while `irq_en_o` is low raises `si_illegal_o`. It writes no link and causes no redirect.
- R10: The enable instruction sets `irq_en_o` from the next cycle on. A software interrupt issued while the flag is set drives `link_we_o = 1` with `link_o = pc_i + 8` and redirects after the slot to the TRAP_VEC parameter (default 0x40). It also clears `irq_en_o` from the next cycle on.
- R11: The disable instruction clears `irq_en_o` from the next cycle on.
- R12: A redirecting instruction placed in a delay slot takes the earlier target as its own `next_pc_o`. Its own target applies to the instruction after it.
- R13: While `instr_vld_i` is low, `link_we_o` and `si_illegal_o` are low and neither the pending redirect nor `irq_en_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld_i | input | 1 | Issue slot holds a valid instruction |
| op_i | input | 4 | Decoded operation code |
| rs_a_i | input | XLEN (32) | First register operand |
| rs_b_i | input | XLEN (32) | Second register operand |
| offset_i | input | OFFW (16) | Signed word offset for relative targets |
| pc_i | input | XLEN (32) | PC of the issued instruction |
| next_pc_o | output | XLEN (32) | PC of the next instruction to execute |
| link_o | output | XLEN (32) | Return address to write |
| link_we_o | output | 1 | Link write enable |
| si_illegal_o | output | 1 | Software interrupt issued while disabled |
| irq_en_o | output | 1 | Interrupt-enable flag |

## Verification
Three outputs follow the issued instruction in the same cycle: the link, its write enable and the illegal flag. The effect of a redirect appears on `next_pc_o` only for the following valid instruction, and changes to the enable flag appear one edge later. The bench drives each instruction on the falling edge and samples all outputs shortly after, before the rising edge. Its model updates the pending target and the flag only after that sample, so every state-dependent expectation belongs to the next issued instruction. A fixed-seed random stream of operations covers both the back-to-back redirect case and the stalled-issue case. Directed sequences cover the comparison boundaries and the interrupt-flag ordering.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [3:0] {
    OP_SEQ  = 4'd0,
    OP_BLT  = 4'd1,
    OP_BLE  = 4'd2,
    OP_BEQ  = 4'd3,
    OP_BNE  = 4'd4,
    OP_JMP  = 4'd5,
    OP_JAL  = 4'd6,
    OP_RETI = 4'd7,
    OP_EI   = 4'd8,
    OP_DI   = 4'd9,
    OP_SI   = 4'd10
  } bcu_op_e;
endpackage

// File: rtl/bcu_compare.sv
module bcu_compare
  import bcu_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  bcu_op_e          op,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  output logic             transfer
);
  logic less;
  logic same;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign less = $signed(opa) < $signed(opb);
    end else begin : g_unsigned
      assign less = opa < opb;
    end
  endgenerate

  assign same = (opa == opb);

  always_comb begin
    case (op)
      OP_BLT:  transfer = less;
      OP_BLE:  transfer = less | same;
      OP_BEQ:  transfer = same;
      OP_BNE:  transfer = ~same;
      OP_JMP,
      OP_JAL,
      OP_RETI: transfer = 1'b1;
      default: transfer = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_target.sv
module bcu_target
  import bcu_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OFFW     = 16,
  parameter logic [XLEN-1:0] TRAP_VEC = 32'h0000_0040
) (
  input  bcu_op_e          op,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [OFFW-1:0]  woff,
  output logic [XLEN-1:0]  dest,
  output logic [XLEN-1:0]  ret_addr
);
  localparam int EXTW = XLEN - OFFW;

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] off_bytes;
  logic [XLEN-1:0] rel_dest;

  assign off_ext   = {{EXTW{woff[OFFW-1]}}, woff};
  assign off_bytes = {off_ext[XLEN-3:0], 2'b00};
  assign rel_dest  = pc + XLEN'(4) + off_bytes;
  assign ret_addr  = pc + XLEN'(8);

  always_comb begin
    case (op)
      OP_JAL:  dest = opb;
      OP_RETI: dest = opa;
      OP_SI:   dest = TRAP_VEC;
      default: dest = rel_dest;
    endcase
  end
endmodule

// File: rtl/bcu_slot_ctrl.sv
module bcu_slot_ctrl #(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic             redirect,
  input  logic [XLEN-1:0]  dest,
  input  logic             ie_set,
  input  logic             ie_clr,
  output logic             pend_o,
  output logic [XLEN-1:0]  pend_dest_o,
  output logic             ie_o
);
  logic            pend_q, pend_d;
  logic [XLEN-1:0] dest_q, dest_d;
  logic            dest_en;
  logic            ie_q, ie_d;

  always_comb begin
    pend_d  = pend_q;
    dest_en = 1'b0;
    dest_d  = dest_q;
    ie_d    = ie_q;
    if (vld) begin
      pend_d = redirect;
      if (redirect) begin
        dest_en = 1'b1;
        dest_d  = dest;
      end
      if (ie_clr)      ie_d = 1'b0;
      else if (ie_set) ie_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ie_q   <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dest_q <= '0;
    else if (dest_en) dest_q <= dest_d;
  end

  assign pend_o      = pend_q;
  assign pend_dest_o = dest_q;
  assign ie_o        = ie_q;

  // R11
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && ie_clr) |=> !ie_o);

  // R10
  ie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && ie_set && !ie_clr) |=> ie_o);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(ie_o) && $stable(pend_o)));

  // R3
  slot_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !redirect) |=> !pend_o);
endmodule

// File: rtl/branch_ctrl_unit.sv
module branch_ctrl_unit
  import bcu_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              OFFW       = 16,
  parameter bit              SIGNED_CMP = 1'b1,
  parameter logic [XLEN-1:0] TRAP_VEC   = 32'h0000_0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_vld_i,
  input  logic [3:0]       op_i,
  input  logic [XLEN-1:0]  rs_a_i,
  input  logic [XLEN-1:0]  rs_b_i,
  input  logic [OFFW-1:0]  offset_i,
  input  logic [XLEN-1:0]  pc_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  link_o,
  output logic             link_we_o,
  output logic             si_illegal_o,
  output logic             irq_en_o
);
  bcu_op_e         op;
  logic            cond_xfer;
  logic [XLEN-1:0] dest;
  logic            is_si;
  logic            si_ok;
  logic            redirect;
  logic            ie_set;
  logic            ie_clr;
  logic            pend;
  logic [XLEN-1:0] pend_dest;
  logic            ie;

  assign op = bcu_op_e'(op_i);

  bcu_compare #(.XLEN(XLEN), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
    .op       (op),
    .opa      (rs_a_i),
    .opb      (rs_b_i),
    .transfer (cond_xfer)
  );

  bcu_target #(.XLEN(XLEN), .OFFW(OFFW), .TRAP_VEC(TRAP_VEC)) u_tgt (
    .op       (op),
    .pc       (pc_i),
    .opa      (rs_a_i),
    .opb      (rs_b_i),
    .woff     (offset_i),
    .dest     (dest),
    .ret_addr (link_o)
  );

  assign is_si    = instr_vld_i && (op == OP_SI);
  assign si_ok    = is_si && ie;
  assign redirect = instr_vld_i && (cond_xfer || si_ok);
  assign ie_set   = (op == OP_EI);
  assign ie_clr   = (op == OP_DI) || si_ok;

  bcu_slot_ctrl #(.XLEN(XLEN)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .vld         (instr_vld_i),
    .redirect    (redirect),
    .dest        (dest),
    .ie_set      (ie_set),
    .ie_clr      (ie_clr),
    .pend_o      (pend),
    .pend_dest_o (pend_dest),
    .ie_o        (ie)
  );

  assign next_pc_o    = pend ? pend_dest : (pc_i + XLEN'(4));
  assign link_we_o    = (instr_vld_i && (op == OP_JAL)) || si_ok;
  assign si_illegal_o = is_si && !ie;
  assign irq_en_o     = ie;

  // R9
  si_illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    si_illegal_o |-> (!irq_en_o && !link_we_o));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld_i |-> (!link_we_o && !si_illegal_o));

  // R7
  jal_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && op_i == 4'd6) |=> (next_pc_o == $past(rs_b_i)));

  // R8
  reti_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && op_i == 4'd7) |=> (next_pc_o == $past(rs_a_i)));

  // R8
  reti_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && op_i == 4'd7) |-> !link_we_o);
endmodule

// File: tb/branch_ctrl_unit_tb.sv
`timescale 1ns/1ps
module branch_ctrl_unit_tb;
  localparam logic [31:0] TRAP = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic [3:0]  op;
  logic [31:0] ra, rb, pc;
  logic [15:0] off;
  logic [31:0] next_pc, link;
  logic        link_we, ill, ie_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        m_pend;
  logic [31:0] m_dest;
  logic        m_ie;
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  branch_ctrl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_vld_i(vld), .op_i(op),
    .rs_a_i(ra), .rs_b_i(rb), .offset_i(off), .pc_i(pc),
    .next_pc_o(next_pc), .link_o(link), .link_we_o(link_we),
    .si_illegal_o(ill), .irq_en_o(ie_out)
  );

  function automatic logic exp_xfer(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      4'd1: return $signed(a) < $signed(b);
      4'd2: return $signed(a) <= $signed(b);
      4'd3: return a == b;
      4'd4: return a != b;
      4'd5, 4'd6, 4'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_dest(input logic [3:0] o, input logic [31:0] p,
                                           input logic [31:0] a, input logic [31:0] b,
                                           input logic [15:0] w);
    if (o == 4'd6) return b;
    if (o == 4'd7) return a;
    if (o == 4'd10) return TRAP;
    return p + 32'd4 + (32'($signed(w)) * 32'd4);
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd1, 4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R10";
      4'd9: return "R11";
      4'd10: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] w, input string tag);
    logic si_ok, xfer, we_e, ill_e;
    logic [31:0] np_e;
    @(negedge clk);
    vld = v; op = o; ra = a; rb = b; off = w; pc = m_pc;
    #1;
    si_ok = v && (o == 4'd10) && m_ie;
    xfer  = v && (exp_xfer(o, a, b) || si_ok);
    we_e  = v && ((o == 4'd6) || si_ok);
    ill_e = v && (o == 4'd10) && !m_ie;
    np_e  = m_pend ? m_dest : m_pc + 32'd4;
    check(m_pend ? "R3" : tag, "next_pc", next_pc, np_e);
    check(tag, "link_we", 32'(link_we), 32'(we_e));
    check(tag, "si_illegal", 32'(ill), 32'(ill_e));
    check(tag, "irq_en", 32'(ie_out), 32'(m_ie));
    if (we_e) check(tag, "link", link, m_pc + 32'd8);
    if (v) begin
      if (xfer) m_dest = exp_dest(o, m_pc, a, b, w);
      m_pend = xfer;
      if (o == 4'd9 || si_ok) m_ie = 1'b0;
      else if (o == 4'd8) m_ie = 1'b1;
      m_pc = np_e;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; vld = 1'b0; op = '0; ra = '0; rb = '0; off = '0; pc = 32'h100;
    m_pend = 1'b0; m_dest = '0; m_ie = 1'b0; m_pc = 32'h100;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    #1;
    check("R1", "irq_en", 32'(ie_out), 32'd0);
    check("R1", "next_pc", next_pc, 32'h104);
    // R4 boundaries
    issue(1, 4'd1, 32'd1, 32'h1234, 16'd8, "R4");
    issue(1, 4'd0, 0, 0, 0, "R3");
    issue(1, 4'd0, 0, 0, 0, "R2");
    issue(1, 4'd1, 32'h1234, 32'd1, 16'd8, "R4");
    issue(1, 4'd0, 0, 0, 0, "R4");
    issue(1, 4'd1, 32'hFFFF_FFFF, 32'd0, 16'hFFFE, "R4");
    issue(1, 4'd0, 0, 0, 0, "R4");
    issue(1, 4'd2, 32'd5, 32'd5, 16'd3, "R4");
    issue(1, 4'd0, 0, 0, 0, "R4");
    // R5
    issue(1, 4'd3, 32'd7, 32'd7, 16'd2, "R5");
    issue(1, 4'd0, 0, 0, 0, "R5");
    issue(1, 4'd4, 32'd7, 32'd7, 16'd2, "R5");
    issue(1, 4'd4, 32'd0, 32'd9, 16'd1, "R5");
    issue(1, 4'd0, 0, 0, 0, "R5");
    // R6, R7, R8
    issue(1, 4'd5, 0, 0, 16'h0010, "R6");
    issue(1, 4'd0, 0, 0, 0, "R6");
    issue(1, 4'd6, 0, 32'h0000_2000, 0, "R7");
    issue(1, 4'd0, 0, 0, 0, "R7");
    issue(1, 4'd7, 32'h0000_3000, 0, 0, "R8");
    issue(1, 4'd0, 0, 0, 0, "R8");
    // R12: redirect in a delay slot
    issue(1, 4'd5, 0, 0, 16'h0040, "R12");
    issue(1, 4'd6, 0, 32'h0000_5000, 0, "R12");
    issue(1, 4'd0, 0, 0, 0, "R12");
    issue(1, 4'd0, 0, 0, 0, "R12");
    // R9, R10, R11, R13
    issue(1, 4'd10, 0, 0, 0, "R9");
    issue(1, 4'd8, 0, 0, 0, "R10");
    issue(0, 4'd9, 0, 0, 0, "R13");
    issue(1, 4'd10, 0, 0, 0, "R10");
    issue(1, 4'd0, 0, 0, 0, "R10");
    issue(1, 4'd10, 0, 0, 0, "R10");
    issue(1, 4'd8, 0, 0, 0, "R11");
    issue(1, 4'd9, 0, 0, 0, "R11");
    issue(1, 4'd10, 0, 0, 0, "R11");
    issue(1, 4'd5, 0, 0, 16'h0004, "R13");
    issue(0, 4'd6, 0, 32'h9999, 0, "R13");
    issue(1, 4'd0, 0, 0, 0, "R13");
    // random stream
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  o;
      logic [31:0] a, b;
      logic        v;
      o = 4'($urandom_range(0, 15));
      v = ($urandom_range(0, 7) != 0);
      a = ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 3)) : $urandom;
      b = ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 3)) : $urandom;
      issue(v, o, a, b, 16'($urandom), v ? tag_of(o) : "R13");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule